// File: doc/BRIEF.md
# PLL Synthesizer Latch Programming Sequencer

This block programs an integer-N frequency synthesizer over a three-wire serial link: a serial clock, a data line and an active-low latch enable. A host supplies a feedback divide count together with the configuration fields of the synthesizer. The host then pulses a start input. The block splits the divide count into the swallow (A) and main (B) counters of a dual-modulus prescaler and builds four 24-bit latch words, each tagged with its address. It then shifts the words out one after another in a fixed order.

On the first accepted programming after reset, the block waits a configurable number of system clock cycles before it sends the feedback-divider word. This gives the synthesizer time to settle after power-up. Later programmings send all four words back to back. A divide count that the counters cannot represent is refused: nothing is sent and an error flag is raised. A separate path samples the synthesizer's lock-detect pin. It reports lock when either of the last two samples was high.

Top module: `pll_prog_seq`

## Requirements
- R1: The two least significant bits of every shifted word carry its latch address: 0 for the reference word, 1 for the feedback-divider (N) word, 2 for the function word and 3 for the initialization word.
- R2: An accepted request sends exactly four words, in the order reference, function, initialization, N.
- R3: On the first accepted request after reset, the enable stays high for at least `WAIT_CYC` system cycles between the initialization word and the N word. Later requests insert no such wait. A rejected request does not use up the first-pass wait.
- R4: Each word is 24 bits, most significant bit first. The data changes only while the serial clock is low and is stable while it is high, so the receiver samples on the rising edge.
- R5: The prescaler select `presc_sel` gives modulus P = 8 for value 0, 16 for value 1 and 32 for values 2 and 3. B = floor(N/P) and A = N - P*B.
- R6: A request is rejected when B < A or when B does not fit in 13 bits. In that case no word is sent, `busy` stays low and `err` goes high one cycle after the start. `err` stays high until the next accepted request clears it.
- R7: In the N word, bits 23:22 are 0, bit 21 is `cp_gain`, bits 20:8 are B, bit 7 is 0 and bits 6:2 are A. In the reference word, bits 23:21 are 0, bit 20 is `lock_prec`, bits 19:18 are `test_sel`, bits 17:16 are `backlash` and bits 15:2 are `ref_div`.
- R8: In the function word, bits 23:22 are `presc_sel`, bit 21 is 0, bits 20:18 are `cp_cur2`, bits 17:15 are `cp_cur1`, bits 14:11 are `pfd_tmo`, bits 10:9 are `fastlk`, bit 8 is `cp_hiz`, bit 7 is `pd_pol`, bits 6:4 are `mux_sel`, bit 3 is `pwr_dn` and bit 2 is `cnt_rst`. The initialization word carries the same bits 23:2.
- R9: `lock_ok` is high exactly when at least one of the two most recent registered samples of `lock_in` is high. A single-cycle pulse on `lock_in` therefore gives two cycles of `lock_ok`.
- R10: The enable is low for the whole of each word and high for at least one serial clock period between words. The serial clock is low whenever the enable is high.
- R11: `busy` rises the cycle after an accepted start and falls together with a one-cycle `done` pulse when the N word completes. A start while `busy` is high is ignored.
- R12: After reset, `busy`, `done`, `err`, `spi_clk` and `lock_ok` are low and `spi_le_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; captures all request inputs |
| ndiv | input | NW | Feedback divide count N |
| presc_sel | input | 2 | Prescaler modulus select |
| cp_gain | input | 1 | Charge-pump gain bit of the N word |
| ref_div | input | 14 | Reference divider |
| lock_prec | input | 1 | Lock-detect precision |
| test_sel | input | 2 | Test mode field |
| backlash | input | 2 | Anti-backlash pulse width |
| cp_cur2 | input | 3 | Second charge-pump current setting |
| cp_cur1 | input | 3 | First charge-pump current setting |
| pfd_tmo | input | 4 | Timeout field |
| fastlk | input | 2 | Fast-lock mode field |
| cp_hiz | input | 1 | Charge-pump three-state |
| pd_pol | input | 1 | Phase-detector polarity |
| mux_sel | input | 3 | Output mux select |
| pwr_dn | input | 1 | Power-down bit |
| cnt_rst | input | 1 | Counter reset bit |
| lock_in | input | 1 | Lock-detect pin from the synthesizer |
| spi_clk | output | 1 | Serial clock, idle low |
| spi_dat | output | 1 | Serial data |
| spi_le_n | output | 1 | Active-low word enable |
| busy | output | 1 | Programming in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request rejected |
| lock_ok | output | 1 | Lock status |

## Verification
A broken counter split or field packing shows up as a wrong word on the serial pins within the first word that carries the field. That is at most about four word times after the start. A wrong word index or address produces an out-of-order sequence or wrong low bits on the same transfer. A stuck first-pass flag appears as a long enable gap, or a missing one, before the N word of the first or second programming. A fault in the handshake state shows as a missing or doubled `done` pulse, extra words, or `busy` held high, all visible within one programming time.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;
  localparam int LW = 24;   // latch word width
  localparam int BW = 13;   // main counter width
  localparam int AW = 5;    // swallow counter width
  localparam int RW = 14;   // reference divider width

  typedef enum logic [1:0] {
    ADDR_REF  = 2'd0,
    ADDR_NDIV = 2'd1,
    ADDR_FUNC = 2'd2,
    ADDR_INIT = 2'd3
  } latch_addr_t;

  typedef struct packed {
    logic [1:0]    presc_sel;
    logic          cp_gain;
    logic [RW-1:0] ref_div;
    logic          lock_prec;
    logic [1:0]    test_sel;
    logic [1:0]    backlash;
    logic [2:0]    cp_cur2;
    logic [2:0]    cp_cur1;
    logic [3:0]    pfd_tmo;
    logic [1:0]    fastlk;
    logic          cp_hiz;
    logic          pd_pol;
    logic [2:0]    mux_sel;
    logic          pwr_dn;
    logic          cnt_rst;
  } pll_cfg_t;
endpackage

// File: rtl/pll_word_pack.sv
module pll_word_pack
  import pll_prog_pkg::*;
#(
  parameter int NW = 18
) (
  input  logic [NW-1:0] ndiv,
  input  pll_cfg_t      cfg,
  output logic [LW-1:0] w_ref,
  output logic [LW-1:0] w_func,
  output logic [LW-1:0] w_init,
  output logic [LW-1:0] w_ndiv,
  output logic          ok
);
  logic [NW-1:0] b_full;
  logic [AW-1:0] a_val;

  always_comb begin
    unique case (cfg.presc_sel)
      2'd0: begin
        b_full = ndiv >> 3;
        a_val  = {2'b00, ndiv[2:0]};
      end
      2'd1: begin
        b_full = ndiv >> 4;
        a_val  = {1'b0, ndiv[3:0]};
      end
      default: begin
        b_full = ndiv >> 5;
        a_val  = ndiv[4:0];
      end
    endcase
  end

  assign ok = ((b_full >> BW) == '0) && (b_full >= NW'(a_val));

  assign w_ref  = {3'b000, cfg.lock_prec, cfg.test_sel, cfg.backlash,
                   cfg.ref_div, ADDR_REF};
  assign w_ndiv = {2'b00, cfg.cp_gain, b_full[BW-1:0], 1'b0, a_val, ADDR_NDIV};
  assign w_func = {cfg.presc_sel, 1'b0, cfg.cp_cur2, cfg.cp_cur1, cfg.pfd_tmo,
                   cfg.fastlk, cfg.cp_hiz, cfg.pd_pol, cfg.mux_sel,
                   cfg.pwr_dn, cfg.cnt_rst, ADDR_FUNC};
  assign w_init = {w_func[LW-1:2], ADDR_INIT};
endmodule

// File: rtl/pll_spi_tx.sv
module pll_spi_tx #(
  parameter int LW   = 24,
  parameter int HALF = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [LW-1:0] word,
  output logic          sclk,
  output logic          sdat,
  output logic          le_n,
  output logic          fin
);
  localparam int CW = $clog2(2 * HALF + 1);
  localparam int IW = $clog2(LW);

  typedef enum logic [1:0] {T_IDLE, T_LO, T_HI, T_GAP} tx_st_t;

  tx_st_t        st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] bitc;
  logic [LW-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= T_IDLE;
      cnt  <= '0;
      bitc <= '0;
      sh   <= '0;
      sclk <= 1'b0;
      sdat <= 1'b0;
      le_n <= 1'b1;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        T_IDLE: if (load) begin
          sh   <= word;
          sdat <= word[LW-1];
          le_n <= 1'b0;
          bitc <= IW'(LW - 1);
          cnt  <= '0;
          st   <= T_LO;
        end
        T_LO: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sclk <= 1'b1;
            st   <= T_HI;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_HI: begin
          if (cnt == CW'(HALF - 1)) begin
            cnt  <= '0;
            sclk <= 1'b0;
            if (bitc == '0) begin
              le_n <= 1'b1;
              st   <= T_GAP;
            end else begin
              bitc <= bitc - 1'b1;
              sh   <= sh << 1;
              sdat <= sh[LW-2];
              st   <= T_LO;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (cnt == CW'(2 * HALF - 1)) begin
            cnt <= '0;
            fin <= 1'b1;
            st  <= T_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R10
  le_clk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    le_n |-> !sclk);

  // R4
  dat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(sdat));
endmodule

// File: rtl/pll_lock_mon.sv
module pll_lock_mon (
  input  logic clk,
  input  logic rst,
  input  logic lock_in,
  output logic lock_ok
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s2      <= 1'b0;
      lock_ok <= 1'b0;
    end else begin
      s1      <= lock_in;
      s2      <= s1;
      lock_ok <= s1 | s2;
    end
  end

  // R9
  lock_follow_chk: assert property (@(posedge clk) disable iff (rst)
    s1 |=> lock_ok);
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq
  import pll_prog_pkg::*;
#(
  parameter int NW       = 18,
  parameter int HALF     = 4,
  parameter int WAIT_CYC = 500000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] ndiv,
  input  logic [1:0]    presc_sel,
  input  logic          cp_gain,
  input  logic [13:0]   ref_div,
  input  logic          lock_prec,
  input  logic [1:0]    test_sel,
  input  logic [1:0]    backlash,
  input  logic [2:0]    cp_cur2,
  input  logic [2:0]    cp_cur1,
  input  logic [3:0]    pfd_tmo,
  input  logic [1:0]    fastlk,
  input  logic          cp_hiz,
  input  logic          pd_pol,
  input  logic [2:0]    mux_sel,
  input  logic          pwr_dn,
  input  logic          cnt_rst,
  input  logic          lock_in,
  output logic          spi_clk,
  output logic          spi_dat,
  output logic          spi_le_n,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          lock_ok
);
  localparam int NWORDS = 4;
  localparam int WCW    = $clog2(WAIT_CYC + 1);

  typedef enum logic [1:0] {Q_IDLE, Q_XFER, Q_HOLD} seq_st_t;

  pll_cfg_t      cfg;
  logic [LW-1:0] p_ref, p_func, p_init, p_ndiv;
  logic          p_ok;
  logic [LW-1:0] words_q [NWORDS];
  logic [1:0]    idx;
  logic          load_r, tx_fin, first;
  logic [WCW-1:0] wcnt;
  seq_st_t       st;

  assign cfg = '{presc_sel: presc_sel, cp_gain: cp_gain, ref_div: ref_div,
                 lock_prec: lock_prec, test_sel: test_sel, backlash: backlash,
                 cp_cur2: cp_cur2, cp_cur1: cp_cur1, pfd_tmo: pfd_tmo,
                 fastlk: fastlk, cp_hiz: cp_hiz, pd_pol: pd_pol,
                 mux_sel: mux_sel, pwr_dn: pwr_dn, cnt_rst: cnt_rst};

  pll_word_pack #(.NW(NW)) u_pack (
    .ndiv(ndiv), .cfg(cfg), .w_ref(p_ref), .w_func(p_func),
    .w_init(p_init), .w_ndiv(p_ndiv), .ok(p_ok)
  );

  pll_spi_tx #(.LW(LW), .HALF(HALF)) u_tx (
    .clk(clk), .rst(rst), .load(load_r), .word(words_q[idx]),
    .sclk(spi_clk), .sdat(spi_dat), .le_n(spi_le_n), .fin(tx_fin)
  );

  pll_lock_mon u_lock (
    .clk(clk), .rst(rst), .lock_in(lock_in), .lock_ok(lock_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= Q_IDLE;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      first  <= 1'b1;
      idx    <= '0;
      load_r <= 1'b0;
      wcnt   <= '0;
      for (int i = 0; i < NWORDS; i++) words_q[i] <= '0;
    end else begin
      done   <= 1'b0;
      load_r <= 1'b0;
      unique case (st)
        Q_IDLE: if (start) begin
          if (p_ok) begin
            words_q[0] <= p_ref;
            words_q[1] <= p_func;
            words_q[2] <= p_init;
            words_q[3] <= p_ndiv;
            busy   <= 1'b1;
            err    <= 1'b0;
            idx    <= 2'd0;
            load_r <= 1'b1;
            st     <= Q_XFER;
          end else begin
            err <= 1'b1;
          end
        end
        Q_XFER: if (tx_fin) begin
          if (idx == 2'd2 && first) begin
            wcnt <= '0;
            st   <= Q_HOLD;
          end else if (idx == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= Q_IDLE;
          end else begin
            idx    <= idx + 1'b1;
            load_r <= 1'b1;
          end
        end
        default: begin
          if (wcnt == WCW'(WAIT_CYC - 1)) begin
            first  <= 1'b0;
            idx    <= 2'd3;
            load_r <= 1'b1;
            st     <= Q_XFER;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> spi_le_n);

  // R11
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
endmodule

// File: tb/sim_pll_prog_seq.sv
`timescale 1ns/1ps
module sim_pll_prog_seq;
  localparam int NW = 18;
  localparam int HALF = 2;
  localparam int WAITC = 300;

  logic clk = 0, rst = 1, start = 0, lock_in = 0;
  logic [NW-1:0] ndiv = 0;
  logic [1:0] presc_sel = 0, test_sel = 0, backlash = 0, fastlk = 0;
  logic cp_gain = 0, lock_prec = 0, cp_hiz = 0, pd_pol = 0, pwr_dn = 0, cnt_rst = 0;
  logic [13:0] ref_div = 0;
  logic [2:0] cp_cur2 = 0, cp_cur1 = 0, mux_sel = 0;
  logic [3:0] pfd_tmo = 0;
  logic spi_clk, spi_dat, spi_le_n, busy, done, err, lock_ok;

  int checks = 0, fails = 0;
  logic [23:0] cap [16];
  int bits [16];
  int gaps [16];
  int capn = 0, donecnt = 0, gcnt = 0, bc = 0;
  logic [23:0] sh = 0;
  logic le_prev = 1, sclk_prev = 0;

  always #10 clk = ~clk;

  pll_prog_seq #(.NW(NW), .HALF(HALF), .WAIT_CYC(WAITC)) u0 (
    .clk, .rst, .start, .ndiv, .presc_sel, .cp_gain, .ref_div, .lock_prec,
    .test_sel, .backlash, .cp_cur2, .cp_cur1, .pfd_tmo, .fastlk, .cp_hiz,
    .pd_pol, .mux_sel, .pwr_dn, .cnt_rst, .lock_in, .spi_clk, .spi_dat,
    .spi_le_n, .busy, .done, .err, .lock_ok
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (!le_prev && spi_le_n) begin
        if (capn < 16) begin cap[capn] = sh; bits[capn] = bc; end
        capn++;
        gcnt = 0;
      end
      if (le_prev && !spi_le_n) begin
        if (capn < 16) gaps[capn] = gcnt;
        sh = 0; bc = 0;
      end
      if (spi_le_n) gcnt++;
      if (!spi_le_n && spi_clk && !sclk_prev) begin sh = {sh[22:0], spi_dat}; bc++; end
      if (done) donecnt++;
    end
    sclk_prev = spi_clk;
    le_prev = spi_le_n;
  end

  function automatic bit expect_words(input int n, output logic [23:0] w [4]);
    int p, b, a;
    logic [23:0] f;
    p = (presc_sel == 0) ? 8 : (presc_sel == 1) ? 16 : 32;
    b = n / p;
    a = n - p * b;
    w[0] = (24'(lock_prec) << 20) | (24'(test_sel) << 18) | (24'(backlash) << 16) | (24'(ref_div) << 2);
    f = (24'(presc_sel) << 22) | (24'(cp_cur2) << 18) | (24'(cp_cur1) << 15) | (24'(pfd_tmo) << 11)
      | (24'(fastlk) << 9) | (24'(cp_hiz) << 8) | (24'(pd_pol) << 7) | (24'(mux_sel) << 4)
      | (24'(pwr_dn) << 3) | (24'(cnt_rst) << 2);
    w[1] = f | 24'd2;
    w[2] = f | 24'd3;
    w[3] = (24'(cp_gain) << 21) | (24'(b & 8191) << 8) | (24'(a & 31) << 2) | 24'd1;
    return (b < 8192) && (b >= a);
  endfunction

  task automatic rand_cfg();
    cp_gain = 1'($urandom); ref_div = 14'($urandom); lock_prec = 1'($urandom);
    test_sel = 2'($urandom); backlash = 2'($urandom); cp_cur2 = 3'($urandom);
    cp_cur1 = 3'($urandom); pfd_tmo = 4'($urandom); fastlk = 2'($urandom);
    cp_hiz = 1'($urandom); pd_pol = 1'($urandom); mux_sel = 3'($urandom);
    pwr_dn = 1'($urandom); cnt_rst = 1'($urandom);
  endtask

  task automatic run(input int n, input bit poke, input bit first_pass);
    logic [23:0] ew [4];
    bit ok;
    ndiv = NW'(n);
    ok = expect_words(n, ew);
    capn = 0; donecnt = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    if (!ok) begin
      chk(err == 1, "R6 err after reject", err, 1);
      chk(busy == 0, "R6 busy after reject", busy, 0);
      repeat (300) @(negedge clk);
      chk(capn == 0, "R6 words sent on reject", capn, 0);
      return;
    end
    chk(busy == 1, "R11 busy after start", busy, 1);
    for (int i = 0; i < 20000 && donecnt == 0; i++) begin
      if (poke && i == 30) begin start = 1; ndiv = NW'(n + 1); end
      if (poke && i == 31) start = 0;
      @(negedge clk);
    end
    repeat (20) @(negedge clk);
    chk(capn == 4, "R2 word count", capn, 4);
    chk(donecnt == 1, "R11 done pulses", donecnt, 1);
    chk(busy == 0, "R11 busy after done", busy, 0);
    chk(err == 0, "R6 err cleared", err, 0);
    for (int k = 0; k < 4 && k < capn; k++) begin
      chk(bits[k] == 24, "R4 bit count", bits[k], 24);
      chk(cap[k][1:0] == ew[k][1:0], "R1 address bits", cap[k][1:0], ew[k][1:0]);
      if (k == 0) chk(cap[k] == ew[k], "R2 R7 reference word", cap[k], ew[k]);
      if (k == 1 || k == 2) chk(cap[k] == ew[k], "R8 function/init word", cap[k], ew[k]);
      if (k == 3) chk(cap[k] == ew[k], "R5 R7 N word", cap[k], ew[k]);
      if (k > 0) chk(gaps[k] >= 2 * HALF, "R10 enable gap", gaps[k], 2 * HALF);
    end
    if (capn >= 4) begin
      if (first_pass) chk(gaps[3] >= WAITC, "R3 first-pass wait", gaps[3], WAITC);
      else chk(gaps[3] < WAITC, "R3 no later wait", gaps[3], WAITC);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int hi;
    void'($urandom(32'h1234_5678));
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk(busy == 0 && done == 0 && err == 0, "R12 status after reset", {busy, done, err}, 0);
    chk(spi_le_n == 1 && spi_clk == 0 && lock_ok == 0, "R12 pins after reset",
        {spi_le_n, spi_clk, lock_ok}, 3'b100);

    // R6 reject: B<A (P=8, N=15 -> B=1, A=7), first pass kept
    rand_cfg(); presc_sel = 0;
    run(15, 0, 0);
    // R3 first accepted pass with wait, B==A boundary (P=8, N=45)
    run(45, 0, 1);
    // R3 later pass, no wait; P=32 via code 3
    presc_sel = 3; rand_cfg();
    run(32 * 100 + 31, 0, 0);
    // R6 overflow: P=8, N=65536 -> B=8192
    presc_sel = 0;
    run(65536, 0, 0);
    // R11 start while busy ignored
    presc_sel = 1; rand_cfg();
    run(16 * 500 + 9, 1, 0);
    // max B at P=32
    presc_sel = 2;
    run(8191 * 32 + 31, 0, 0);
    // R5 random valid requests
    for (int t = 0; t < 16; t++) begin
      int p, b, a;
      presc_sel = 2'($urandom); rand_cfg();
      p = (presc_sel == 0) ? 8 : (presc_sel == 1) ? 16 : 32;
      b = 32 + int'($urandom % 8160);
      a = int'($urandom % p);
      run(b * p + a, 0, 0);
    end

    // R9 lock status
    lock_in = 0; repeat (4) @(negedge clk);
    chk(lock_ok == 0, "R9 lock low", lock_ok, 0);
    lock_in = 1; repeat (4) @(negedge clk);
    chk(lock_ok == 1, "R9 lock high", lock_ok, 1);
    lock_in = 0; repeat (4) @(negedge clk);
    lock_in = 1; @(negedge clk); lock_in = 0;
    hi = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (lock_ok) hi++; end
    chk(hi == 2, "R9 single-sample pulse", hi, 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule